// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter

This block turns one HDLC frame, supplied a byte at a time, into a single serial bit line. The line moves forward by exactly one bit on each cycle in which the transmit strobe `bit_en` is high, so the line rate is set by the strobe and not by the clock. A start pulse captures a station address byte and a control byte. The payload bytes then arrive over a valid/ready handshake, and a last-byte marker closes the payload. The block frames the body with flags, inserts zero bits where five ones in a row occur, and appends a 16-bit check sequence.

Between frames the line carries flags without a break. An abort request during a frame drops the frame and sends the abort pattern. A payload byte that is missing when it is needed has the same result. A host uses the block by pulsing `start` while the line is idle and then streaming payload bytes as `pl_ready` requests them. The last byte is marked with `pl_last`.

Top module: `hdlc_tx_ser`

## Requirements
- R1: While reset is asserted and until the first strobe after reset, `tx_bit` is 1 and `pl_ready` is 0.
- R2: The line changes only in a cycle with `bit_en` high. With no frame in progress it repeats the flag 0x7E, least-significant bit first (0,1,1,1,1,1,1,0).
- R3: A `start` pulse while idle captures `tx_addr` and `tx_ctrl`. Later changes to those inputs have no effect on the frame. The current idle flag finishes first. The line then carries an opening flag, the address, the control byte, the payload bytes, the check sequence and a closing flag, with every byte sent LSB first.
- R4: In the address, control, payload and check-sequence bits, a 0 is inserted after every five consecutive 1s. This includes a 0 owed after the final check-sequence bit, which goes before the closing flag. Flags and abort patterns are never stuffed, and each flag clears the run count.
- R5: The check sequence is the bit-reflected CRC with polynomial x^16+x^12+x^5+1 (0x8408 reflected) and start value 0xFFFF. It covers the unstuffed address, control and payload bits, and it is sent as the ones' complement, bit 0 first.
- R6: `pl_ready` is high only in a strobe cycle that sends bit 7 of the control byte or of a payload byte not marked last. A byte moves when `pl_ready` and `pl_valid` are both high. After a byte marked with `pl_last`, the check sequence follows.
- R7: In a strobe cycle that sends an inserted 0, `pl_ready` stays low. The byte handover then moves to the next strobe.
- R8: If `abort` is high while a frame is in progress (opening flag through check sequence), the next emitted bit begins the abort pattern 0,1,1,1,1,1,1,1. The abort is held over to the next strobe when it arrives between strobes. The line then returns to idle flags.
- R9: If `pl_ready` is high while `pl_valid` is low, bit 7 is still sent, and the abort pattern follows directly.
- R10: The all-ones broadcast address 0xFF is sent like any other address, with zero insertion applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Transmit strobe; one line bit per high cycle |
| start | input | 1 | Frame start command, honoured while idle |
| abort | input | 1 | Abort request for the frame in progress |
| tx_addr | input | BYTE_W | Station address byte, captured at start |
| tx_ctrl | input | BYTE_W | Control byte, captured at start |
| pl_data | input | BYTE_W | Payload byte |
| pl_valid | input | 1 | Payload byte available |
| pl_last | input | 1 | Marks the final payload byte |
| pl_ready | output | 1 | Payload byte taken this cycle if valid |
| tx_bit | output | 1 | Serial line output |

## Verification
Zero insertion and the byte handover to the payload interface can fall on the same strobe: a run of five ones can end exactly at bit 6 of a byte, so the inserted 0 takes the strobe that would otherwise send bit 7 and load the next byte. Frames built from the 0xFF broadcast address and all-ones payload bytes force this case at several byte edges, under both a continuous strobe and a sparse one. The bench marks each expected bit as stuffed or as a handover bit. Before every edge it compares `pl_ready` with that mark, so a handover that fires during an inserted 0 is reported directly. An abort that arrives on a strobe cycle and one that arrives between strobes are also both driven, and both are judged by the first bit that follows.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_ABORT
  } txst_t;

  localparam logic [7:0] FLAG_PAT = 8'h7E;

endpackage

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16 #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  POLY = 16'h8408,
  parameter logic [W-1:0]  INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic upd,
  input  logic shift,
  input  logic din,
  output logic lsb
);

  logic [W-1:0] r_q, r_d;
  logic         fb;

  always_comb begin
    fb  = r_q[0] ^ din;
    r_d = r_q;
    if (init)       r_d = INIT;
    else if (upd)   r_d = (r_q >> 1) ^ (fb ? POLY : '0);
    else if (shift) r_d = {1'b1, r_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= INIT;
    else        r_q <= r_d;
  end

  assign lsb = r_q[0];

endmodule

// File: rtl/hdlc_ones_run.sv
module hdlc_ones_run #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic body,
  input  logic stuff,
  input  logic din,
  output logic due
);

  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] RUN_V = CW'(RUN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (!body || stuff) cnt_d = '0;
      else if (din)       cnt_d = cnt_q + 1'b1;
      else                cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign due = (cnt_q == RUN_V);

endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
#(
  parameter int              BYTE_W  = 8,
  parameter int              FCS_W   = 16,
  parameter int              RUN_MAX = 5,
  parameter logic [FCS_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [FCS_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              start,
  input  logic              abort,
  input  logic [BYTE_W-1:0] tx_addr,
  input  logic [BYTE_W-1:0] tx_ctrl,
  input  logic [BYTE_W-1:0] pl_data,
  input  logic              pl_valid,
  input  logic              pl_last,
  output logic              pl_ready,
  output logic              tx_bit
);

  localparam int IDX_W  = $clog2(FCS_W);
  localparam int BSEL_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] BYTE_END = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] FCS_END  = IDX_W'(FCS_W - 1);

  txst_t             state_q, state_d, eff_st;
  logic [IDX_W-1:0]  idx_q, idx_d, eff_idx;
  logic [BYTE_W-1:0] addr_q, addr_d, ctrl_q, ctrl_d, byte_q, byte_d;
  logic              last_q, last_d, spend_q, spend_d, apend_q, apend_d;
  logic              bit_q, bit_d;
  logic [BSEL_W-1:0] bsel;
  logic in_frame, abort_act, go_open, body, stuff_due, stuff_now;
  logic emit, end_here, load_pt, line_bit, crc_lsb;

  // which frame section the current strobe belongs to, abort overriding
  assign in_frame  = state_q inside {ST_OPEN, ST_ADDR, ST_CTRL, ST_DATA, ST_FCS};
  assign abort_act = (abort | apend_q) & in_frame;
  assign eff_st    = abort_act ? ST_ABORT : state_q;
  assign eff_idx   = abort_act ? '0 : idx_q;
  assign bsel      = eff_idx[BSEL_W-1:0];
  assign go_open   = spend_q | (start & (state_q == ST_IDLE));

  assign body      = eff_st inside {ST_ADDR, ST_CTRL, ST_DATA, ST_FCS};
  assign stuff_now = stuff_due & (body | (eff_st == ST_CLOSE));
  assign emit      = bit_en & ~stuff_now;
  assign end_here  = (eff_st == ST_FCS) ? (eff_idx == FCS_END) : (eff_idx == BYTE_END);
  assign load_pt   = (eff_idx == BYTE_END) &
                     ((eff_st == ST_CTRL) | ((eff_st == ST_DATA) & ~last_q));
  assign pl_ready  = emit & load_pt;
  assign tx_bit    = bit_q;

  always_comb begin
    unique case (eff_st)
      ST_ADDR:  line_bit = addr_q[bsel];
      ST_CTRL:  line_bit = ctrl_q[bsel];
      ST_DATA:  line_bit = byte_q[bsel];
      ST_FCS:   line_bit = ~crc_lsb;
      ST_ABORT: line_bit = (eff_idx != '0);
      default:  line_bit = FLAG_PAT[bsel];
    endcase
  end

  hdlc_fcs16 #(.W(FCS_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_fcs (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (bit_en & (eff_st == ST_OPEN)),
    .upd   (emit & (eff_st inside {ST_ADDR, ST_CTRL, ST_DATA})),
    .shift (emit & (eff_st == ST_FCS)),
    .din   (line_bit),
    .lsb   (crc_lsb)
  );

  hdlc_ones_run #(.RUN(RUN_MAX)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (bit_en),
    .body  (body),
    .stuff (stuff_now),
    .din   (line_bit),
    .due   (stuff_due)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    ctrl_d  = ctrl_q;
    byte_d  = byte_q;
    last_d  = last_q;
    spend_d = spend_q;
    apend_d = apend_q;
    bit_d   = bit_q;

    if (start && state_q == ST_IDLE) begin
      spend_d = 1'b1;
      addr_d  = tx_addr;
      ctrl_d  = tx_ctrl;
    end

    if (!in_frame)             apend_d = 1'b0;
    else if (abort && !bit_en) apend_d = 1'b1;

    if (bit_en) begin
      bit_d = stuff_now ? 1'b0 : line_bit;
      if (abort_act) apend_d = 1'b0;
    end

    if (emit) begin
      state_d = eff_st;
      idx_d   = end_here ? '0 : eff_idx + 1'b1;
      if (end_here) begin
        unique case (eff_st)
          ST_IDLE: if (go_open) begin
            state_d = ST_OPEN;
            spend_d = 1'b0;
          end
          ST_OPEN: state_d = ST_ADDR;
          ST_ADDR: state_d = ST_CTRL;
          ST_CTRL, ST_DATA: begin
            if (eff_st == ST_DATA && last_q) state_d = ST_FCS;
            else if (pl_valid) begin
              state_d = ST_DATA;
              byte_d  = pl_data;
              last_d  = pl_last;
            end else state_d = ST_ABORT;
          end
          ST_FCS:  state_d = ST_CLOSE;
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      ctrl_q  <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      spend_q <= 1'b0;
      apend_q <= 1'b0;
      bit_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      ctrl_q  <= ctrl_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      spend_q <= spend_d;
      apend_q <= apend_d;
      bit_q   <= bit_d;
    end
  end

endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk
  import hdlc_tx_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  bit_en,
  input logic  abort,
  input logic  tx_bit,
  input logic  pl_ready,
  input logic  pl_valid,
  input logic  stuff_now,
  input logic  in_frame,
  input txst_t st
);

  logic       en_d;
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      run_q <= '0;
    end else begin
      en_d <= bit_en;
      if (en_d) run_q <= tx_bit ? ((run_q == 4'hF) ? run_q : run_q + 1'b1) : 4'd0;
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));                                     // R2

  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now) |=> !tx_bit);                               // R4

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 4'd7);                                                   // R4

  AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> bit_en);                                             // R6

  AST_STUFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |-> !pl_ready);                                         // R7

  AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && abort && in_frame) |=> (!tx_bit && st == ST_ABORT));   // R8

  AST_UNDERRUN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_ready && !pl_valid) |=> st == ST_ABORT);                      // R9

endmodule

bind hdlc_tx_ser hdlc_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .abort     (abort),
  .tx_bit    (tx_bit),
  .pl_ready  (pl_ready),
  .pl_valid  (pl_valid),
  .stuff_now (stuff_now),
  .in_frame  (in_frame),
  .st        (state_q)
);

// File: tb/sim_hdlc_tx_ser.sv
`timescale 1ns/1ps
module sim_hdlc_tx_ser;

  localparam logic [7:0] FLAG = 8'h7E;

  logic clk = 1'b0;
  logic rst_n, bit_en, start, abort, pl_valid, pl_last, pl_ready, tx_bit;
  logic [7:0] tx_addr, tx_ctrl, pl_data;

  always #2.5 clk = ~clk;

  hdlc_tx_ser u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start), .abort(abort),
    .tx_addr(tx_addr), .tx_ctrl(tx_ctrl), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_last(pl_last), .pl_ready(pl_ready), .tx_bit(tx_bit)
  );

  // expected entries: {handover bit, stuffed bit, value}
  logic [2:0] exp_q[$];
  logic [7:0] pay_d[$];
  logic       pay_l[$];
  logic [7:0] pbuf[8];
  string      cur_tag = "R3";
  int tests = 0, fails = 0, phase = 0, ones = 0, en_div = 1, cyc = 0;
  logic [15:0] crc;
  logic mon_on = 1'b0, en_prev = 1'b0, xfer_prev = 1'b0, last_bit = 1'b1, done = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    c  = c >> 1;
    if (fb) c = c ^ 16'h8408;
    return c;
  endfunction

  task automatic push(input logic v, input logic stf, input logic rdy);
    exp_q.push_back({rdy, stf, v});
  endtask

  task automatic body_bit(input logic b, input logic rdy);
    if (ones == 5) begin push(1'b0, 1'b1, 1'b0); ones = 0; end
    push(b, 1'b0, rdy);
    ones = b ? ones + 1 : 0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #0.5;
    while (exp_q.size() != 0) begin @(negedge clk); #0.5; end
  endtask

  task automatic run_frame(input logic [7:0] a, input logic [7:0] c, input int n,
                           input bit underrun, input string tag);
    logic [15:0] fcs;
    wait_idle();
    cur_tag = tag;
    for (int i = phase; i < 8; i++) push(FLAG[i], 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) push(FLAG[i], 1'b0, 1'b0);
    ones = 0;
    crc = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin body_bit(a[i], 1'b0); crc = crc_bit(crc, a[i]); end
    for (int i = 0; i < 8; i++) begin body_bit(c[i], i == 7); crc = crc_bit(crc, c[i]); end
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        body_bit(pbuf[k][i], (i == 7) && (k != n - 1 || underrun));
        crc = crc_bit(crc, pbuf[k][i]);
      end
    if (underrun) begin
      for (int i = 0; i < 8; i++) push(i != 0, 1'b0, 1'b0);
    end else begin
      fcs = ~crc;
      for (int i = 0; i < 16; i++) body_bit(fcs[i], 1'b0);
      if (ones == 5) push(1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) push(FLAG[i], 1'b0, 1'b0);
    end
    for (int k = 0; k < n; k++) begin
      pay_d.push_back(pbuf[k]);
      pay_l.push_back(!underrun && k == n - 1);
    end
    tx_addr = a; tx_ctrl = c; start = 1'b1;
    @(negedge clk); #0.5;
    start = 1'b0;
    tx_addr = ~a; tx_ctrl = ~c;   // R3: must not reach the line
  endtask

  task automatic finish_frame(input string tag);
    wait_idle();
    check(pay_d.size() == 0, tag, 16'(pay_d.size()), 16'd0);   // R6: all payload taken
  endtask

  // monitor and payload driver, one pass per cycle
  always begin
    @(negedge clk);
    if (mon_on) begin
      if (en_prev) begin
        logic       e;
        string      tg;
        if (exp_q.size() != 0) begin
          e = exp_q[0][0]; void'(exp_q.pop_front()); phase = 0; tg = cur_tag;
        end else begin
          e = FLAG[phase]; phase = (phase + 1) % 8; tg = "R2";
        end
        check(tx_bit === e, tg, 16'(tx_bit), 16'(e));
        last_bit = tx_bit;
      end else begin
        check(tx_bit === last_bit, "R2 hold", 16'(tx_bit), 16'(last_bit));
      end
      if (xfer_prev && pay_d.size() != 0) begin
        void'(pay_d.pop_front()); void'(pay_l.pop_front());
      end
    end
    cyc++;
    bit_en   = mon_on && (cyc % en_div == 0);
    pl_valid = pay_d.size() != 0;
    pl_data  = (pay_d.size() != 0) ? pay_d[0] : 8'h00;
    pl_last  = (pay_l.size() != 0) ? pay_l[0] : 1'b0;
    #1.0;
    xfer_prev = pl_ready && pl_valid;
    if (mon_on) begin
      if (bit_en && exp_q.size() != 0 && exp_q[0][1])
        check(!pl_ready, "R7", 16'(pl_ready), 16'd0);
      else
        check(pl_ready === (bit_en && exp_q.size() != 0 && exp_q[0][2]), "R6",
              16'(pl_ready), 16'(bit_en && exp_q.size() != 0 && exp_q[0][2]));
    end
    en_prev = bit_en;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; start = 1'b0; abort = 1'b0;
    tx_addr = 8'h00; tx_ctrl = 8'h00; pl_data = 8'h00; pl_valid = 1'b0; pl_last = 1'b0;
    repeat (3) @(negedge clk);
    #0.5;
    check(tx_bit === 1'b1, "R1", 16'(tx_bit), 16'd1);
    check(pl_ready === 1'b0, "R1", 16'(pl_ready), 16'd0);
    @(negedge clk);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    #0.5;
    check(tx_bit === 1'b1, "R1 after release", 16'(tx_bit), 16'd1);

    // R2: idle flags, sparse strobe then continuous
    en_div = 3;
    repeat (40) @(negedge clk);
    en_div = 1;
    repeat (13) @(negedge clk);

    // R3 and R5: ordinary frame
    pbuf[0] = 8'h00; pbuf[1] = 8'hA5; pbuf[2] = 8'h3C;
    run_frame(8'h35, 8'h10, 3, 1'b0, "R3/R5");
    finish_frame("R3");

    // R10, R4, R7: broadcast address and all-ones bytes under a sparse strobe
    en_div = 3;
    pbuf[0] = 8'hFF; pbuf[1] = 8'hFF; pbuf[2] = 8'h7E; pbuf[3] = 8'hF8;
    run_frame(8'hFF, 8'h3E, 4, 1'b0, "R10/R4");
    finish_frame("R10");

    // same pattern with a continuous strobe
    en_div = 1;
    pbuf[0] = 8'hFF; pbuf[1] = 8'hFF; pbuf[2] = 8'hFF;
    run_frame(8'hFF, 8'hFF, 3, 1'b0, "R4/R7");
    finish_frame("R7");

    // R6 and R5: single-byte payload
    pbuf[0] = 8'h5A;
    run_frame(8'h01, 8'h00, 1, 1'b0, "R6/R5");
    finish_frame("R6");

    // R8: abort between strobes
    en_div = 2;
    for (int k = 0; k < 8; k++) pbuf[k] = 8'h11 * k[7:0];
    run_frame(8'h42, 8'h13, 8, 1'b0, "R8");
    repeat (40) @(negedge clk);
    #0.5;
    abort = 1'b1;
    exp_q.delete();
    for (int i = 0; i < 8; i++) push(i != 0, 1'b0, 1'b0);
    pay_d.delete(); pay_l.delete();
    @(negedge clk); #0.5;
    abort = 1'b0;
    wait_idle();
    check(exp_q.size() == 0, "R8 drained", 16'(exp_q.size()), 16'd0);

    // R8: abort on a strobe cycle
    en_div = 1;
    for (int k = 0; k < 6; k++) pbuf[k] = 8'hC3 ^ k[7:0];
    run_frame(8'h24, 8'h77, 6, 1'b0, "R8");
    repeat (45) @(negedge clk);
    #0.5;
    abort = 1'b1;
    exp_q.delete();
    for (int i = 0; i < 8; i++) push(i != 0, 1'b0, 1'b0);
    pay_d.delete(); pay_l.delete();
    @(negedge clk); #0.5;
    abort = 1'b0;
    wait_idle();

    // R9: payload runs dry
    pbuf[0] = 8'h0F; pbuf[1] = 8'h1F; pbuf[2] = 8'hF0;
    run_frame(8'h80, 8'h01, 3, 1'b1, "R9");
    finish_frame("R9");

    // recovery frame after the aborts
    pbuf[0] = 8'h7E; pbuf[1] = 8'h7E;
    run_frame(8'h7E, 8'hFF, 2, 1'b0, "R4");
    finish_frame("R4");

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule